// File: doc/BRIEF.md
# Serial Interrupt Frame Host Controller

This block is the host end of a single-wire serialized interrupt bus. It drives the shared line through a separate value and output-enable and reads the resolved line level back. Each bus cycle has four parts. First the host drives a start pulse. Then come 32 interrupt data frames, each three clocks long. Finally the host drives a stop pulse. On the first clock of frame n the host samples the line, and a low level means interrupt n is active.

When a cycle is complete, the 32 collected bits are published together with a one-clock valid strobe. The width of the stop pulse tells every device which mode the next cycle runs in. In continuous mode the host opens a new cycle after a fixed idle gap. In quiet mode the host waits for one of two events: a start request from the host side, or a peripheral pulling the line low for one clock. In the second case the host continues the pulse that the peripheral began.

Top module: `sirq_host`

## Requirements
- R1: During reset and after it, `line_oe`, `status_valid`, `irq_status` and `quiet_mode` are 0, so the block is in continuous mode. The second rising clock edge after reset release begins the first start pulse.
- R2: A host-initiated start pulse drives the line low (`line_oe`=1, `line_o`=0) for 4 clocks when `start_sel`=00, 6 clocks when it is 01, and 8 clocks when it is 10 or 11.
- R3: After every low pulse it drives, the host drives the line high for exactly one clock. On the next clock it releases the line (`line_oe`=0).
- R4: The start turnaround clock is followed by 32 frames of three clocks each: sample, recovery, turnaround. Bit n of the vector is 1 exactly when the line is low on the sample clock of frame n. The host never drives the line during frames.
- R5: `irq_status` changes only in the clock where `status_valid` is 1. That clock is the one right after the turnaround of frame 31, and `status_valid` lasts one clock. Values collected mid-cycle are never shown.
- R6: The stop pulse begins in the same clock as `status_valid`. It is 2 low clocks if `next_quiet` was 1 at the end of frame 31, and 3 low clocks if it was 0.
- R7: `quiet_mode` takes the mode selected by the stop pulse in the clock after the stop turnaround, and changes at no other time.
- R8: In continuous mode the next start pulse begins after two idle clocks that follow the stop turnaround. A low line or `host_req` during those idle clocks has no effect.
- R9: In quiet mode the host keeps the line released until a request arrives. If `host_req` is high at a clock edge in idle, a full start pulse of the selected width begins in the next clock.
- R10: In quiet mode, if a peripheral pulls the released line low for one clock in idle, the host drives low for the selected width minus one clock. The total low time therefore equals the selected width.
- R11: If a peripheral start and `host_req` occur in the same idle clock, the rule of R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Resolved level of the shared interrupt line |
| line_o | output | 1 | Level the host drives when enabled |
| line_oe | output | 1 | Host output enable for the line |
| start_sel | input | 2 | Start pulse width: 00=4, 01=6, 1x=8 clocks |
| next_quiet | input | 1 | Mode for the next cycle: 1 quiet, 0 continuous |
| host_req | input | 1 | Host-side start request, used in quiet mode |
| irq_status | output | 32 | Interrupt vector from the last complete cycle |
| status_valid | output | 1 | One-clock strobe when `irq_status` is updated |
| quiet_mode | output | 1 | Current mode: 1 quiet, 0 continuous |

## Verification
Two start sources can land on the same idle clock in quiet mode: a peripheral pulling the line low, and the host-side request. The bench asserts both on one clock with an 8-clock width selected. It then checks that the host drives exactly 7 low clocks, so the line is low for 8 clocks in total and not 9. The publication of the vector and the start of the stop pulse also fall in one clock. That clock is checked against the pattern sent and against the stop width each mode select calls for.

// File: rtl/sirq_pkg.sv
// Shared types and helpers for the serial interrupt host.
// Assumes the start width select is two bits wide.
package sirq_pkg;

    localparam int SIRQ_CNT_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_SREC,
        ST_STRN,
        ST_FSAMP,
        ST_FREC,
        ST_FTRN,
        ST_STOP,
        ST_PREC,
        ST_PTRN
    } sirq_st_e;

    // Number of low clocks in a start pulse for a given select code
    function automatic logic [SIRQ_CNT_W-1:0] start_clocks(input logic [1:0] sel);
        case (sel)
            2'b00:   return SIRQ_CNT_W'(4);
            2'b01:   return SIRQ_CNT_W'(6);
            default: return SIRQ_CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/sirq_seq.sv
// Cycle sequencer: walks the start, frame and stop phases and holds the mode.
// Assumes line_i is already synchronous to clk and that IDLE_GAP >= 1.
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ  = 32,
    parameter int IDLE_GAP = 2,
    localparam int IW = $clog2(NUM_IRQ),
    localparam int GW = $clog2(IDLE_GAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic [1:0]    start_sel,
    input  logic          next_quiet,
    input  logic          host_req,
    output sirq_st_e      state,
    output logic [IW-1:0] idx,
    output logic          quiet_mode
);

    logic [SIRQ_CNT_W-1:0] pcnt;
    logic [GW-1:0]         gcnt;
    logic                  next_q;

    // Phase sequencing, pulse counting, frame index and mode update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pcnt       <= '0;
            gcnt       <= '0;
            idx        <= '0;
            quiet_mode <= 1'b0;
            next_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (quiet_mode) begin
                        if (!line_i) begin
                            state <= ST_START;
                            pcnt  <= start_clocks(start_sel) - SIRQ_CNT_W'(2);
                        end else if (host_req) begin
                            state <= ST_START;
                            pcnt  <= start_clocks(start_sel) - SIRQ_CNT_W'(1);
                        end
                    end else if (gcnt == GW'(IDLE_GAP - 1)) begin
                        state <= ST_START;
                        pcnt  <= start_clocks(start_sel) - SIRQ_CNT_W'(1);
                        gcnt  <= '0;
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                ST_START: begin
                    if (pcnt == '0) state <= ST_SREC;
                    else            pcnt  <= pcnt - SIRQ_CNT_W'(1);
                end
                ST_SREC: state <= ST_STRN;
                ST_STRN: begin
                    state <= ST_FSAMP;
                    idx   <= '0;
                end
                ST_FSAMP: state <= ST_FREC;
                ST_FREC:  state <= ST_FTRN;
                ST_FTRN: begin
                    if (idx == IW'(NUM_IRQ - 1)) begin
                        state  <= ST_STOP;
                        next_q <= next_quiet;
                        pcnt   <= next_quiet ? SIRQ_CNT_W'(1) : SIRQ_CNT_W'(2);
                    end else begin
                        state <= ST_FSAMP;
                        idx   <= idx + IW'(1);
                    end
                end
                ST_STOP: begin
                    if (pcnt == '0) state <= ST_PREC;
                    else            pcnt  <= pcnt - SIRQ_CNT_W'(1);
                end
                ST_PREC: state <= ST_PTRN;
                ST_PTRN: begin
                    state      <= ST_IDLE;
                    quiet_mode <= next_q;
                    gcnt       <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sirq_collect.sv
// Frame sampler: gathers one bit per frame and publishes the whole vector at cycle end.
// Assumes state and idx come from the sequencer of the same clock domain.
module sirq_collect
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int IW = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sirq_st_e           state,
    input  logic [IW-1:0]      idx,
    input  logic               line_i,
    output logic [NUM_IRQ-1:0] irq_status,
    output logic               status_valid
);

    logic [NUM_IRQ-1:0] acc;

    // Capture the active-low line on each sample clock
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc      <= '0;
        else if (state == ST_FSAMP) acc[idx] <= ~line_i;
    end

    // Publish the gathered vector once the last frame ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_status   <= '0;
            status_valid <= 1'b0;
        end else begin
            status_valid <= 1'b0;
            if (state == ST_FTRN && idx == IW'(NUM_IRQ - 1)) begin
                irq_status   <= acc;
                status_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sirq_drive.sv
// Line driver: decodes the phase into output value and enable.
// Assumes an external pull-up holds the line high while released.
module sirq_drive
    import sirq_pkg::*;
(
    input  sirq_st_e state,
    output logic     line_o,
    output logic     line_oe
);

    // Low during pulses, high on their recovery clock, released elsewhere
    always_comb begin
        line_o  = 1'b1;
        line_oe = 1'b0;
        case (state)
            ST_START, ST_STOP: begin
                line_o  = 1'b0;
                line_oe = 1'b1;
            end
            ST_SREC, ST_PREC: line_oe = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sirq_host.sv
// Serial interrupt host: top level joining sequencer, sampler and driver.
// Assumes all inputs are synchronous to clk.
module sirq_host
    import sirq_pkg::*;
#(
    parameter int NUM_IRQ  = 32,
    parameter int IDLE_GAP = 2,
    localparam int IW = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    output logic               line_o,
    output logic               line_oe,
    input  logic [1:0]         start_sel,
    input  logic               next_quiet,
    input  logic               host_req,
    output logic [NUM_IRQ-1:0] irq_status,
    output logic               status_valid,
    output logic               quiet_mode
);

    sirq_st_e      state;
    logic [IW-1:0] idx;

    sirq_seq #(.NUM_IRQ(NUM_IRQ), .IDLE_GAP(IDLE_GAP)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .start_sel(start_sel), .next_quiet(next_quiet), .host_req(host_req),
        .state(state), .idx(idx), .quiet_mode(quiet_mode)
    );

    sirq_collect #(.NUM_IRQ(NUM_IRQ)) u_col (
        .clk(clk), .rst_n(rst_n), .state(state), .idx(idx), .line_i(line_i),
        .irq_status(irq_status), .status_valid(status_valid)
    );

    sirq_drive u_drv (
        .state(state), .line_o(line_o), .line_oe(line_oe)
    );

endmodule

// File: rtl/sirq_host_chk.sv
// Property checker for the serial interrupt host, observing its ports only.
module sirq_host_chk #(
    parameter int NUM_IRQ = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_o,
    input logic               line_oe,
    input logic [NUM_IRQ-1:0] irq_status,
    input logic               status_valid,
    input logic               quiet_mode
);

    logic [3:0] lowrun;

    // Count consecutive host-driven low clocks
    always_ff @(posedge clk) begin
        if (!rst_n)                  lowrun <= '0;
        else if (line_oe && !line_o) lowrun <= lowrun + 4'd1;
        else                         lowrun <= '0;
    end

    // R2
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_o) |-> lowrun < 4'd8);

    // R3
    high_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_o) |=> !line_oe);

    // R3
    release_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> $past(line_o));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid);

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_status) |-> status_valid);

    // R6
    stop_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> (line_oe && !line_o));

    // R7
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quiet_mode) |-> (!$past(line_oe) && $past(line_oe, 2) && $past(line_o, 2)));

endmodule

bind sirq_host sirq_host_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_o(line_o), .line_oe(line_oe),
    .irq_status(irq_status), .status_valid(status_valid), .quiet_mode(quiet_mode)
);

// File: tb/sim_sirq_host.sv
`timescale 1ns/1ps
module sim_sirq_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_low = 1'b0;
    logic        host_req = 1'b0;
    logic [1:0]  start_sel = 2'b00;
    logic        next_quiet = 1'b0;
    logic        line_o, line_oe, status_valid, quiet_mode;
    logic [31:0] irq_status;
    logic        line_i;
    logic [31:0] prev_status = 32'h0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // Wired line: host drives when enabled, else a device may pull low, else pull-up
    assign line_i = line_oe ? line_o : ~dev_low;

    always #4 clk = ~clk;

    sirq_host u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_o(line_o), .line_oe(line_oe),
        .start_sel(start_sel), .next_quiet(next_quiet), .host_req(host_req),
        .irq_status(irq_status), .status_valid(status_valid), .quiet_mode(quiet_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Find the next host low pulse from the current negedge; wc counts negedges waited
    task automatic get_pulse(output int wc, output int w);
        wc = 0;
        w  = 0;
        while (!(line_oe && !line_o) && wc < 400) begin
            @(negedge clk);
            wc++;
        end
        while (line_oe && !line_o && w < 20) begin
            w++;
            @(negedge clk);
        end
        chk(line_oe && line_o, "R3", "high clock after pulse", {30'd0, line_oe, line_o}, 32'h3);
        @(negedge clk);
        chk(!line_oe, "R3", "release after high", {31'd0, line_oe}, 32'h0);
    endtask

    // Act as devices through 32 frames, then check publication and stop width
    task automatic run_frames(input logic [31:0] v, input bit q);
        int wc, w;
        next_quiet = q;
        for (int n = 0; n < 32; n++) begin
            @(negedge clk);
            dev_low = v[n];
            chk(!line_oe, "R4", "host released in frame", {31'd0, line_oe}, 32'h0);
            @(negedge clk);
            dev_low = 1'b0;
            @(negedge clk);
            if (n == 16) begin
                chk(!status_valid, "R5", "no strobe mid cycle", {31'd0, status_valid}, 32'h0);
                chk(irq_status == prev_status, "R5", "status held mid cycle", irq_status, prev_status);
            end
        end
        @(negedge clk);
        chk(status_valid, "R5", "strobe after frame 31", {31'd0, status_valid}, 32'h1);
        chk(irq_status == v, "R4", "collected vector", irq_status, v);
        prev_status = v;
        get_pulse(wc, w);
        chk(wc == 0, "R6", "stop begins with strobe", wc, 0);
        chk(w == (q ? 2 : 3), "R6", "stop width", w, q ? 2 : 3);
    endtask

    task automatic t_reset;
        int wc, w;
        repeat (3) @(negedge clk);
        chk(!line_oe && !status_valid && !quiet_mode, "R1", "outputs in reset",
            {29'd0, line_oe, status_valid, quiet_mode}, 32'h0);
        chk(irq_status == 32'h0, "R1", "status in reset", irq_status, 32'h0);
        start_sel = 2'b00;
        rst_n = 1'b1;
        get_pulse(wc, w);
        chk(wc == 2, "R1", "first start timing", wc, 2);
        chk(w == 4, "R2", "start width sel 00", w, 4);
        run_frames(32'hA5C3_0F81, 1'b0);
        chk(!quiet_mode, "R7", "continuous kept", {31'd0, quiet_mode}, 32'h0);
    endtask

    task automatic t_widths;
        int wc, w;
        logic [31:0] pats [3];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h0000_0000;
        pats[2] = 32'h8000_0001;
        for (int k = 1; k < 4; k++) begin
            start_sel = 2'(k);
            get_pulse(wc, w);
            chk(wc == 3, "R8", "continuous gap", wc, 3);
            chk(w == (k == 1 ? 6 : 8), "R2", "start width", w, (k == 1) ? 6 : 8);
            run_frames(pats[k-1], 1'b0);
        end
    endtask

    task automatic t_cont_ignore;
        int wc, w;
        start_sel = 2'b00;
        host_req = 1'b1;
        dev_low = 1'b1;
        @(negedge clk);
        chk(!line_oe, "R8", "idle 1 ignores line and request", {31'd0, line_oe}, 32'h0);
        @(negedge clk);
        chk(!line_oe, "R8", "idle 2 ignores line and request", {31'd0, line_oe}, 32'h0);
        dev_low = 1'b0;
        host_req = 1'b0;
        get_pulse(wc, w);
        chk(wc == 1, "R8", "start after two idle clocks", wc, 1);
        chk(w == 4, "R8", "width unaffected", w, 4);
        run_frames(32'h1234_5678, 1'b1);
        @(negedge clk);
        chk(quiet_mode, "R7", "quiet after 2-clock stop", {31'd0, quiet_mode}, 32'h1);
    endtask

    task automatic t_quiet_host;
        int wc, w;
        bit stayed = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (line_oe) stayed = 1'b0;
        end
        chk(stayed, "R9", "quiet idle holds", {31'd0, stayed}, 32'h1);
        start_sel = 2'b01;
        host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        get_pulse(wc, w);
        chk(wc == 0, "R9", "start right after request", wc, 0);
        chk(w == 6, "R9", "host start width", w, 6);
        run_frames(32'hDEAD_BEEF, 1'b1);
    endtask

    task automatic t_quiet_periph;
        int wc, w;
        repeat (3) @(negedge clk);
        start_sel = 2'b01;
        dev_low = 1'b1;
        @(negedge clk);
        dev_low = 1'b0;
        get_pulse(wc, w);
        chk(wc == 0, "R10", "host continues at once", wc, 0);
        chk(w == 5, "R10", "host part of start", w, 5);
        run_frames(32'h0F0F_F0F0, 1'b1);
    endtask

    task automatic t_both;
        int wc, w;
        repeat (2) @(negedge clk);
        start_sel = 2'b10;
        dev_low = 1'b1;
        host_req = 1'b1;
        @(negedge clk);
        dev_low = 1'b0;
        host_req = 1'b0;
        get_pulse(wc, w);
        chk(wc == 0, "R11", "start follows coincident requests", wc, 0);
        chk(w == 7, "R11", "host part with both requests", w, 7);
        run_frames(32'h7654_3210, 1'b0);
        @(negedge clk);
        chk(!quiet_mode, "R7", "back to continuous", {31'd0, quiet_mode}, 32'h0);
        start_sel = 2'b00;
        get_pulse(wc, w);
        chk(wc == 2, "R8", "continuous restart gap", wc, 2);
        chk(w == 4, "R2", "start width after switch", w, 4);
    endtask

    initial begin
        t_reset();
        t_widths();
        t_cont_ignore();
        t_quiet_host();
        t_quiet_periph();
        t_both();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule